// File: doc/BRIEF.md
# Serial Peripheral Slave Port with Idle Recovery

This block is the serial front end of a data converter. An external controller reaches the converter's register file and conversion results through four wires: an active-low select, a serial clock, a data line into the block and a data line out of it. The block runs on a fast system clock and treats all three inputs as asynchronous, passing each through a synchronizer chain before use. Edges of the serial clock are found from the synchronized copy. Each serial clock cycle moves one bit in each direction, most significant bit first. The controller idles the clock low. The block changes its output bit on the rising edge and captures the input bit on the falling edge. Completed input bytes and requests for the next output byte go to the command logic behind the port, which is not part of this block.

The output line is driven only while a byte is being sent on purpose, so input and output can share one bidirectional wire. The block gives an output value and a separate drive enable for the pad. Raising select clears all bit state. A controller that keeps select low all the time can still recover a broken transfer. If the serial clock stays low for a set number of conversion periods, the bit state is cleared in the same way. An active-low ready flag tells the controller that a fresh conversion result is waiting.

Top module: `serport_top`

## Requirements
- R1: The input bit is sampled at each falling serial clock edge while selected, most significant bit first. On the eighth falling edge of a byte, `rx_valid_o` pulses for one cycle and `rx_data_o` holds the assembled byte.
- R2: `dout_o` changes only on a rising serial clock edge. On the k-th rising edge of a byte (k = 1..8) it shows bit 8-k of the `tx_data_i` value sampled at the first rising edge of that byte.
- R3: `tx_next_o` pulses for one cycle after the eighth rising edge of each byte, and at no other time.
- R4: While select is high (inactive), both bit counters are held at zero and `dout_oe_o` is low. A partly shifted byte is discarded, and the next byte starts aligned at its most significant bit.
- R5: With select held low for the whole run, consecutive bytes follow each other with no gap and no gating by select.
- R6: After `TIMEOUT_PERIODS` (default 32) pulses of `result_tick_i` with the serial clock low and no serial clock edge between them, the port clears its bit state and drives `dout_oe_o` low. The next serial clock pulse starts a new byte.
- R7: Any serial clock edge restarts the idle count, and pulses that arrive while the serial clock is high are not counted. A byte interrupted by fewer than `TIMEOUT_PERIODS` low-clock pulses between edges therefore completes intact.
- R8: `dout_oe_o` takes the value of `tx_en_i` at the first rising edge of each byte and holds it until the next first rising edge, a select release or an idle reset.
- R9: `drdy_n_o` is high after reset. It goes low in the cycle after a `result_tick_i` pulse and returns high after a received byte completes. A tick wins over a completion in the same cycle.
- R10: After reset, `dout_oe_o`, `rx_valid_o` and `tx_next_o` are low and `drdy_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Active-low select from the controller, asynchronous |
| sclk_i | input | 1 | Serial clock from the controller, idles low, asynchronous |
| din_i | input | 1 | Serial data from the controller, asynchronous |
| dout_o | output | 1 | Serial data to the controller |
| dout_oe_o | output | 1 | Pad drive enable for `dout_o`; low means high impedance |
| result_tick_i | input | 1 | One-cycle pulse per conversion period, marking a new result |
| drdy_n_o | output | 1 | Active-low flag showing that a new result is ready |
| rx_valid_o | output | 1 | One-cycle pulse when a received byte is complete |
| rx_data_o | output | 8 | Last received byte |
| tx_data_i | input | 8 | Byte to send, sampled at the first rising edge of a byte |
| tx_en_i | input | 1 | Drive the output line during the byte that is starting |
| tx_next_o | output | 1 | One-cycle pulse asking for the next transmit byte |

## Verification
The assertions assume that each serial clock level lasts several system clock cycles. They also assume that the data input is stable around each falling edge and that `result_tick_i` is a single-cycle pulse. Under these conditions an edge found after synchronization matches a real controller edge. The bench holds every serial clock phase for eight system cycles and changes the input bit only together with the rising edge. It sends ticks one cycle wide and spaced apart, and it issues ticks only while the serial clock is idle low or held high.

// File: rtl/serport_pkg.sv
package serport_pkg;

    localparam int SP_BYTE_W = 8;
    localparam int SP_BIT_CW = $clog2(SP_BYTE_W);

    typedef logic [SP_BIT_CW-1:0] bitcnt_t;
    typedef logic [SP_BYTE_W-1:0] byte_t;

    // Edge information derived from the synchronized serial clock.
    typedef struct packed {
        logic rise;   // rising edge while selected
        logic fall;   // falling edge while selected
        logic any;    // any level change, select ignored
    } sclk_edge_t;

    // One shift lane: data register plus bit position.
    typedef struct packed {
        byte_t   sh;
        bitcnt_t cnt;
    } lane_t;

    function automatic sclk_edge_t find_edges(logic now, logic prev, logic selected);
        sclk_edge_t e;
        e.any  = now ^ prev;
        e.rise = selected & now & ~prev;
        e.fall = selected & ~now & prev;
        return e;
    endfunction

    function automatic logic is_last_bit(bitcnt_t c);
        return c == bitcnt_t'(SP_BYTE_W - 1);
    endfunction

endpackage

// File: rtl/serport_sync.sv
module serport_sync #(
    parameter int               W       = 3,
    parameter int               STAGES  = 2,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
        end else begin
            chain_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/serport_idle.sv
module serport_idle #(
    parameter int TIMEOUT_PERIODS = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic sclk_low_i,
    input  logic edge_i,
    output logic expire_o
);

    localparam int CNT_W = $clog2(TIMEOUT_PERIODS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_PERIODS - 1);

    logic [CNT_W-1:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (rst || edge_i) begin
            idle_cnt <= '0;
            expire_o <= 1'b0;
        end else begin
            expire_o <= 1'b0;
            if (tick_i && sclk_low_i) begin
                if (idle_cnt == LAST) begin
                    idle_cnt <= '0;
                    expire_o <= 1'b1;
                end else begin
                    idle_cnt <= idle_cnt + 1'b1;
                end
            end
        end
    end

    assert_idle_bound_R6: assert property (@(posedge clk) disable iff (rst)
        idle_cnt < CNT_W'(TIMEOUT_PERIODS));

    assert_expire_needs_tick_R6: assert property (@(posedge clk) disable iff (rst)
        expire_o |-> $past(tick_i) && $past(sclk_low_i));

    assert_edge_restarts_R7: assert property (@(posedge clk) disable iff (rst)
        edge_i |=> !expire_o);

endmodule

// File: rtl/serport_shift.sv
module serport_shift
    import serport_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear_i,
    input  logic  rise_i,
    input  logic  fall_i,
    input  logic  din_i,
    input  byte_t tx_data_i,
    input  logic  tx_en_i,
    output logic  rx_valid_o,
    output byte_t rx_data_o,
    output logic  tx_next_o,
    output logic  dout_o,
    output logic  dout_oe_o
);

    lane_t rx_q;
    lane_t tx_q;

    // Receive lane: capture on falling edges.
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q       <= '0;
            rx_valid_o <= 1'b0;
        end else begin
            rx_valid_o <= 1'b0;
            if (clear_i) begin
                rx_q.cnt <= '0;
            end else if (fall_i) begin
                rx_q.sh    <= {rx_q.sh[SP_BYTE_W-2:0], din_i};
                rx_q.cnt   <= rx_q.cnt + 1'b1;
                rx_valid_o <= is_last_bit(rx_q.cnt);
            end
        end
    end

    assign rx_data_o = rx_q.sh;

    // Transmit lane: update output on rising edges.
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q      <= '0;
            dout_o    <= 1'b0;
            dout_oe_o <= 1'b0;
            tx_next_o <= 1'b0;
        end else begin
            tx_next_o <= 1'b0;
            if (clear_i) begin
                tx_q.cnt  <= '0;
                dout_oe_o <= 1'b0;
            end else if (rise_i) begin
                if (tx_q.cnt == '0) begin
                    dout_o    <= tx_data_i[SP_BYTE_W-1];
                    tx_q.sh   <= {tx_data_i[SP_BYTE_W-2:0], 1'b0};
                    dout_oe_o <= tx_en_i;
                end else begin
                    dout_o  <= tx_q.sh[SP_BYTE_W-1];
                    tx_q.sh <= {tx_q.sh[SP_BYTE_W-2:0], 1'b0};
                end
                tx_q.cnt  <= tx_q.cnt + 1'b1;
                tx_next_o <= is_last_bit(tx_q.cnt);
            end
        end
    end

    assert_rx_single_R1: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |=> !rx_valid_o);

    assert_dout_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !rise_i |=> $stable(dout_o));

    assert_txnext_after_rise_R3: assert property (@(posedge clk) disable iff (rst)
        tx_next_o |-> $past(rise_i));

    assert_clear_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> !rx_valid_o && !tx_next_o && !dout_oe_o);

    assert_oe_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!rise_i && !clear_i) |=> $stable(dout_oe_o));

endmodule

// File: rtl/serport_top.sv
module serport_top
    import serport_pkg::*;
#(
    parameter int SYNC_STAGES     = 2,
    parameter int TIMEOUT_PERIODS = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_n_i,
    input  logic                 sclk_i,
    input  logic                 din_i,
    output logic                 dout_o,
    output logic                 dout_oe_o,
    input  logic                 result_tick_i,
    output logic                 drdy_n_o,
    output logic                 rx_valid_o,
    output logic [SP_BYTE_W-1:0] rx_data_o,
    input  logic [SP_BYTE_W-1:0] tx_data_i,
    input  logic                 tx_en_i,
    output logic                 tx_next_o
);

    // Order inside the synchronized bundle: {select, clock, data}.
    localparam logic [2:0] SYNC_RST = 3'b100;

    logic [2:0] pins_s;
    logic       cs_n_s, sclk_s, din_s;
    logic       sclk_prev_q;
    sclk_edge_t edges;
    logic       idle_expire;
    logic       lane_clear;

    serport_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) sync_i (
        .clk (clk),
        .rst (rst),
        .d_i ({cs_n_i, sclk_i, din_i}),
        .q_o (pins_s)
    );

    assign {cs_n_s, sclk_s, din_s} = pins_s;

    always_ff @(posedge clk) begin
        if (rst) sclk_prev_q <= 1'b0;
        else     sclk_prev_q <= sclk_s;
    end

    assign edges = find_edges(sclk_s, sclk_prev_q, ~cs_n_s);

    serport_idle #(
        .TIMEOUT_PERIODS (TIMEOUT_PERIODS)
    ) idle_i (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (result_tick_i),
        .sclk_low_i (~sclk_s),
        .edge_i     (edges.any),
        .expire_o   (idle_expire)
    );

    assign lane_clear = cs_n_s | idle_expire;

    serport_shift shift_i (
        .clk        (clk),
        .rst        (rst),
        .clear_i    (lane_clear),
        .rise_i     (edges.rise),
        .fall_i     (edges.fall),
        .din_i      (din_s),
        .tx_data_i  (tx_data_i),
        .tx_en_i    (tx_en_i),
        .rx_valid_o (rx_valid_o),
        .rx_data_o  (rx_data_o),
        .tx_next_o  (tx_next_o),
        .dout_o     (dout_o),
        .dout_oe_o  (dout_oe_o)
    );

    // Ready flag: set low by a new result, released by a finished byte.
    always_ff @(posedge clk) begin
        if (rst)                drdy_n_o <= 1'b1;
        else if (result_tick_i) drdy_n_o <= 1'b0;
        else if (rx_valid_o)    drdy_n_o <= 1'b1;
    end

    assert_select_hiz_R4: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> !dout_oe_o);

    assert_idle_hiz_R6: assert property (@(posedge clk) disable iff (rst)
        idle_expire |=> !dout_oe_o);

    assert_drdy_low_R9: assert property (@(posedge clk) disable iff (rst)
        result_tick_i |=> !drdy_n_o);

    assert_drdy_release_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(drdy_n_o) |-> $past(rx_valid_o));

    assert_no_edge_unselected_R4: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |-> !edges.rise && !edges.fall);

endmodule

// File: tb/serport_top_tb_top.sv
`timescale 1ns/1ps
module serport_top_tb_top;

    localparam int HALF  = 8;
    localparam int LIMIT = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
    logic       dout, dout_oe, tick = 1'b0, drdy_n, rx_valid, tx_next;
    logic [7:0] rx_data, tx_data = 8'h00;
    logic       tx_en = 1'b0;

    int errors = 0;
    int checks = 0;
    int rx_count = 0;
    int txn_count = 0;
    logic [7:0] last_rx = 8'h00;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    serport_top dut_i (
        .clk(clk), .rst(rst), .cs_n_i(cs_n), .sclk_i(sclk), .din_i(din),
        .dout_o(dout), .dout_oe_o(dout_oe), .result_tick_i(tick),
        .drdy_n_o(drdy_n), .rx_valid_o(rx_valid), .rx_data_o(rx_data),
        .tx_data_i(tx_data), .tx_en_i(tx_en), .tx_next_o(tx_next)
    );

    // Pulse monitors, sampled away from the active edge.
    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            rx_count++;
            last_rx = rx_data;
        end
        if (!rst && tx_next) txn_count++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pick_byte();
        return 8'($urandom_range(0, 255));
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One serial bit; optional ticks while the clock is held high.
    task automatic bit_io(input logic b, input int hi_ticks, output logic d, output logic oe);
        @(negedge clk);
        din  = b;
        sclk = 1'b1;
        wait_clk(HALF);
        d  = dout;
        oe = dout_oe;
        for (int i = 0; i < hi_ticks; i++) begin
            tick = 1'b1; wait_clk(1); tick = 1'b0; wait_clk(2);
        end
        sclk = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            wait_clk(2);
        end
    endtask

    // Full byte exchange with checks on every side.
    task automatic xfer(input logic [7:0] mosi, input logic [7:0] miso, input logic en, input string tag);
        logic [7:0] got;
        logic d, oe;
        bit oe_ok;
        int rx0, tn0;
        rx0 = rx_count; tn0 = txn_count; oe_ok = 1'b1;
        tx_data = miso; tx_en = en;
        for (int i = 7; i >= 0; i--) begin
            bit_io(mosi[i], 0, d, oe);
            got[i] = d;
            if (oe !== en) oe_ok = 1'b0;
        end
        wait_clk(4);
        check(rx_count == rx0 + 1 && last_rx == mosi, {"R1 rx byte ", tag}, last_rx, mosi);
        if (en) check(got == miso, {"R2 tx bits ", tag}, got, miso);
        check(oe_ok, {"R8 drive enable ", tag}, oe_ok, 1);
        check(txn_count == tn0 + 1, {"R3 next request ", tag}, txn_count - tn0, 1);
    endtask

    initial begin
        logic d, oe;
        int rx0;
        logic [7:0] b;
        void'($urandom(32'h5EED_1234));
        wait_clk(5);
        rst = 1'b0;
        wait_clk(3);
        // R10 reset state
        check(dout_oe == 1'b0 && rx_valid == 1'b0 && tx_next == 1'b0,
              "R10 outputs quiet", {dout_oe, rx_valid, tx_next}, 0);
        check(drdy_n == 1'b1, "R10 ready flag high", drdy_n, 1);

        // R5 select held low, random back-to-back bytes
        cs_n = 1'b0;
        wait_clk(6);
        for (int n = 0; n < 16; n++) begin
            xfer(pick_byte(), pick_byte(), 1'($urandom_range(0, 1)), "R5 stream");
        end
        // directed corner patterns
        xfer(8'h00, 8'hFF, 1'b1, "R2 all ones out");
        xfer(8'hFF, 8'h00, 1'b1, "R1 all ones in");
        xfer(8'h81, 8'h7E, 1'b0, "R8 no drive");

        // R4 select release in mid byte
        tx_en = 1'b1; tx_data = 8'hC3;
        for (int i = 0; i < 3; i++) bit_io(1'b1, 0, d, oe);
        rx0 = rx_count;
        cs_n = 1'b1;
        wait_clk(6);
        check(dout_oe == 1'b0, "R4 hiz on release", dout_oe, 0);
        check(rx_count == rx0, "R4 no partial byte", rx_count - rx0, 0);
        cs_n = 1'b0;
        wait_clk(6);
        xfer(8'h3C, 8'h5A, 1'b1, "R4 realigned");

        // R6 idle reset with select low
        tx_en = 1'b1; tx_data = 8'hA5;
        for (int i = 0; i < 5; i++) bit_io(1'b0, 0, d, oe);
        rx0 = rx_count;
        ticks(LIMIT);
        wait_clk(4);
        check(dout_oe == 1'b0, "R6 hiz after idle", dout_oe, 0);
        check(rx_count == rx0, "R6 no partial byte", rx_count - rx0, 0);
        xfer(8'h96, 8'h69, 1'b1, "R6 restart");

        // R7 edges restart the count, high clock does not count
        b = 8'hB7;
        tx_data = 8'h11; tx_en = 1'b1;
        rx0 = rx_count;
        for (int i = 7; i >= 5; i--) bit_io(b[i], 0, d, oe);
        ticks(LIMIT - 1);
        bit_io(b[4], 0, d, oe);
        ticks(LIMIT - 1);
        bit_io(b[3], LIMIT + 8, d, oe);
        for (int i = 2; i >= 0; i--) bit_io(b[i], 0, d, oe);
        wait_clk(4);
        check(rx_count == rx0 + 1 && last_rx == b, "R7 byte survives", last_rx, b);
        check(dout_oe == 1'b1, "R7 still driving", dout_oe, 1);

        // R9 ready flag
        ticks(1);
        check(drdy_n == 1'b0, "R9 low after result", drdy_n, 0);
        xfer(pick_byte(), pick_byte(), 1'b1, "R9 read");
        check(drdy_n == 1'b1, "R9 high after byte", drdy_n, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule